// File: doc/BRIEF.md
# DDR Self-Refresh Wake Sequencer

This block restores a DDR SDRAM from self-refresh after the system leaves a low-power sleep. When a wake request arrives, the block raises clock enable and puts the self-refresh exit command on the command bus twice. The second copy is there because the controller loses its state while asleep. The block then holds NOP for a minimum settling time, which is expressed in picoseconds and converted to cycles with a clock-period parameter.

Next it issues a burst of AUTO REFRESH commands, one for every row of the device, with a programmable number of NOP cycles between them to cover the refresh cycle time. Only when the last refresh and its spacing have finished does it raise the refresh-enable output, which hands the device to the periodic refresh engine, together with a done flag.

The sequencer is normally started from its idle state after reset, or from its done state when other logic has put the device back to sleep. A wake request that arrives while a sequence is running has no effect.

Top module: `srx_wake_seq`

## Requirements
- R1: During and after reset, with no wake request, `cke` is 0, `cmd` is NOP (2'b00), and `ref_en` and `done` are 0. All four stay unchanged while `wake` stays low.
- R2: A `wake` sampled high in the idle or done state makes `cmd` SR_EXIT (2'b01) on the next two consecutive cycles, and on no third cycle.
- R3: After the two exit commands, `cmd` is NOP for exactly NOP_CYC cycles before the first refresh. NOP_CYC is the ceiling of NOP_MIN_PS / CLK_PS, with a minimum of 1.
- R4: The burst is ROWS AUTO REFRESH commands (2'b10). Between consecutive refreshes there are exactly G NOP cycles, where G is the `rfc_gap` value sampled in the cycle that accepted the wake.
- R5: `ref_en` and `done` rise together exactly 2 + NOP_CYC + ROWS*(1+G) cycles after the first exit command appears. This is after the last refresh and its G NOP cycles. Both then stay high with `cmd` NOP until the next wake.
- R6: While a sequence is running, a high `wake` and any change of `rfc_gap` have no effect on the command trace.
- R7: A wake accepted in the done state restarts the sequence. In the first exit cycle `done` and `ref_en` are 0 and `cke` is 1.
- R8: The row down-counter is $clog2(ROWS+1) bits wide (14 bits for 8192 rows) and stops at zero. Exactly ROWS refreshes are issued per sequence, never more.
- R9: `cke` stays 1 from the first exit command through the done state, and every non-NOP command is issued with `cke` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake | input | 1 | Wake request, sampled in the idle or done state |
| rfc_gap | input | GAP_W | NOP cycles between refreshes, captured when a wake is accepted |
| cmd | output | 2 | Command: 00 NOP, 01 SR_EXIT, 10 AUTO REFRESH |
| cke | output | 1 | Clock enable to the SDRAM |
| ref_en | output | 1 | Enables the periodic refresh engine |
| done | output | 1 | Wake sequence complete |

## Verification
Every output is registered, so the first SR_EXIT appears in the cycle right after the edge that samples `wake`. Each later result has a fixed cycle index counted from that first exit cycle: the first refresh at index 2+NOP_CYC, refresh k at 2+NOP_CYC+k*(1+G), and `done` at 2+NOP_CYC+ROWS*(1+G). The bench samples every cycle on the falling edge and compares it with a model function that has that index as its argument. Random wake pulses and `rfc_gap` changes are applied only in cycles whose following edge falls inside the sequence.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_SRX  = 2'b01,
        CMD_AREF = 2'b10
    } srx_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EXIT1 = 3'd1,
        ST_EXIT2 = 3'd2,
        ST_SETTLE = 3'd3,
        ST_REF   = 3'd4,
        ST_GAP   = 3'd5,
        ST_DONE  = 3'd6
    } srx_state_e;

    typedef struct packed {
        srx_cmd_e cmd;
        logic     cke;
        logic     ref_en;
        logic     done;
    } srx_out_t;

endpackage

// File: rtl/srx_down_cnt.sv
// Loadable down-counter that parks at zero instead of wrapping.
module srx_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/srx_out_reg.sv
// Registers the pin-level outputs decoded from the next state.
module srx_out_reg
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  srx_state_e state_nxt,
    output logic [1:0] cmd_o,
    output logic       cke_o,
    output logic       ref_en_o,
    output logic       done_o
);
    srx_out_t out_d, out_q;

    always_comb begin
        out_d.cmd    = CMD_NOP;
        out_d.cke    = (state_nxt != ST_IDLE);
        out_d.ref_en = 1'b0;
        out_d.done   = 1'b0;
        case (state_nxt)
            ST_EXIT1, ST_EXIT2: out_d.cmd = CMD_SRX;
            ST_REF:             out_d.cmd = CMD_AREF;
            ST_DONE: begin
                out_d.ref_en = 1'b1;
                out_d.done   = 1'b1;
            end
            default: out_d.cmd = CMD_NOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.cmd    <= CMD_NOP;
            out_q.cke    <= 1'b0;
            out_q.ref_en <= 1'b0;
            out_q.done   <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cmd_o    = out_q.cmd;
    assign cke_o    = out_q.cke;
    assign ref_en_o = out_q.ref_en;
    assign done_o   = out_q.done;
endmodule

// File: rtl/srx_wake_seq.sv
module srx_wake_seq
    import srx_pkg::*;
#(
    parameter int ROWS       = 8192,
    parameter int CLK_PS     = 2500,
    parameter int NOP_MIN_PS = 80000,
    parameter int GAP_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake,
    input  logic [GAP_W-1:0] rfc_gap,
    output logic [1:0]       cmd,
    output logic             cke,
    output logic             ref_en,
    output logic             done
);
    localparam int NOP_RAW = (NOP_MIN_PS + CLK_PS - 1) / CLK_PS;
    localparam int NOP_CYC = (NOP_RAW < 1) ? 1 : NOP_RAW;
    localparam int CNT_W   = $clog2(ROWS + 1);
    localparam int NOP_W   = (NOP_CYC > 1) ? $clog2(NOP_CYC) : 1;
    localparam int WAIT_W  = (NOP_W > GAP_W) ? NOP_W : GAP_W;

    typedef struct packed {
        srx_state_e       state;
        logic [GAP_W-1:0] gap;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic              wait_load, wait_dec, wait_zero;
    logic [WAIT_W-1:0] wait_val;
    logic              row_load, row_dec, row_zero;

    always_comb begin
        fsm_d     = fsm_q;
        wait_load = 1'b0;
        wait_dec  = 1'b0;
        wait_val  = '0;
        row_load  = 1'b0;
        row_dec   = 1'b0;
        case (fsm_q.state)
            ST_IDLE, ST_DONE: begin
                if (wake) begin
                    fsm_d.state = ST_EXIT1;
                    fsm_d.gap   = rfc_gap;
                end
            end
            ST_EXIT1: fsm_d.state = ST_EXIT2;
            ST_EXIT2: begin
                fsm_d.state = ST_SETTLE;
                wait_load   = 1'b1;
                wait_val    = WAIT_W'(NOP_CYC - 1);
                row_load    = 1'b1;
            end
            ST_SETTLE: begin
                if (wait_zero) begin
                    fsm_d.state = ST_REF;
                    row_dec     = 1'b1;
                end else begin
                    wait_dec = 1'b1;
                end
            end
            ST_REF: begin
                if (fsm_q.gap == '0) begin
                    if (row_zero) begin
                        fsm_d.state = ST_DONE;
                    end else begin
                        fsm_d.state = ST_REF;
                        row_dec     = 1'b1;
                    end
                end else begin
                    fsm_d.state = ST_GAP;
                    wait_load   = 1'b1;
                    wait_val    = WAIT_W'(fsm_q.gap - GAP_W'(1));
                end
            end
            ST_GAP: begin
                if (wait_zero) begin
                    if (row_zero) begin
                        fsm_d.state = ST_DONE;
                    end else begin
                        fsm_d.state = ST_REF;
                        row_dec     = 1'b1;
                    end
                end else begin
                    wait_dec = 1'b1;
                end
            end
            default: fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= ST_IDLE;
            fsm_q.gap   <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    srx_down_cnt #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .dec      (wait_dec),
        .is_zero  (wait_zero)
    );

    srx_down_cnt #(.W(CNT_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (row_load),
        .load_val (CNT_W'(ROWS)),
        .dec      (row_dec),
        .is_zero  (row_zero)
    );

    srx_out_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (fsm_d.state),
        .cmd_o     (cmd),
        .cke_o     (cke),
        .ref_en_o  (ref_en),
        .done_o    (done)
    );
endmodule

// File: rtl/srx_wake_seq_chk.sv
module srx_wake_seq_chk #(
    parameter int ROWS    = 8192,
    parameter int NOP_CYC = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd,
    input logic       cke,
    input logic       ref_en,
    input logic       done
);
    localparam int RW   = $clog2(ROWS + 1) + 1;
    localparam int SE_W = $clog2(NOP_CYC + 3);
    localparam logic [RW-1:0]   ROWS_V = RW'(ROWS);
    localparam logic [SE_W-1:0] SE_MAX = SE_W'(NOP_CYC + 2);
    localparam logic [SE_W-1:0] SE_MIN = SE_W'(NOP_CYC);

    logic [RW-1:0]   ref_seen;
    logic [SE_W-1:0] since_exit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_seen   <= '0;
            since_exit <= '0;
        end else if (cmd == 2'b01) begin
            ref_seen   <= '0;
            since_exit <= '0;
        end else begin
            if (cmd == 2'b10) ref_seen <= ref_seen + RW'(1);
            if (since_exit < SE_MAX) since_exit <= since_exit + SE_W'(1);
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd == 2'b00 && !done && !ref_en));

    a_r2_exit_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && $past(cmd) != 2'b01) |=> cmd == 2'b01);

    a_r2_exit_no_third: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && $past(cmd) == 2'b01) |=> cmd != 2'b01);

    a_r3_settle_min: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b10 && ref_seen == '0) |-> since_exit >= SE_MIN);

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b10 |-> ref_seen < ROWS_V);

    a_r5_done_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (ref_seen == ROWS_V && ref_en));

    a_r9_cke_for_cmds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 2'b00 || done) |-> cke);
endmodule

bind srx_wake_seq srx_wake_seq_chk #(.ROWS(ROWS), .NOP_CYC(NOP_CYC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .cke    (cke),
    .ref_en (ref_en),
    .done   (done)
);

// File: tb/sim_srx_wake_seq.sv
`timescale 1ns/1ps
module sim_srx_wake_seq;
    localparam int ROWS   = 8192;
    localparam int CLK_PS = 20000;
    localparam int NOP_PS = 80000;
    localparam int N      = (NOP_PS + CLK_PS - 1) / CLK_PS;
    localparam logic [1:0] NOP = 2'b00, SRX = 2'b01, AREF = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake = 1'b0;
    logic [7:0] rfc_gap = '0;
    logic [1:0] cmd;
    logic       cke, ref_en, done;

    int total_checks = 0;
    int bad_checks = 0;

    always #10 clk = ~clk;

    srx_wake_seq #(.ROWS(ROWS), .CLK_PS(CLK_PS), .NOP_MIN_PS(NOP_PS), .GAP_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wake(wake), .rfc_gap(rfc_gap),
        .cmd(cmd), .cke(cke), .ref_en(ref_en), .done(done)
    );

    function automatic logic [1:0] exp_cmd(input int i, input int g);
        int j;
        if (i < 2) return SRX;
        j = i - 2;
        if (j < N) return NOP;
        j = j - N;
        if (j < ROWS * (1 + g)) return ((j % (1 + g)) == 0) ? AREF : NOP;
        return NOP;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_seq(input int g, input bit from_done);
        int total = 2 + N + ROWS * (1 + g);
        int mism = 0, first_i = -1, first_act = 0, first_exp = 0;
        int cke_bad = 0, dn_bad = 0, nref = 0, first_aref = -1, done_at = -1;
        int busy_wakes = 0;
        logic [1:0] c0 = NOP, c1 = NOP, c2 = NOP;
        @(negedge clk);
        rfc_gap = 8'(g);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        for (int i = 0; i <= total + 3; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 0) c0 = cmd;
            if (i == 1) c1 = cmd;
            if (i == 2) c2 = cmd;
            if (cmd !== exp_cmd(i, g)) begin
                if (mism == 0) begin
                    first_i = i; first_act = int'(cmd); first_exp = int'(exp_cmd(i, g));
                end
                mism++;
            end
            if (cke !== 1'b1) cke_bad++;
            if (done !== (i >= total) || ref_en !== (i >= total)) dn_bad++;
            if (cmd === AREF) begin
                nref++;
                if (first_aref < 0) first_aref = i;
            end
            if (done === 1'b1 && done_at < 0) done_at = i;
            if (i == 0 && from_done)
                check(done === 1'b0 && ref_en === 1'b0 && cke === 1'b1,
                      "R7 restart from done", int'({done, ref_en, cke}), 1);
            rfc_gap = 8'($urandom);
            if (i < total && ($urandom % 64) == 0) begin
                wake = 1'b1;
                busy_wakes++;
            end else begin
                wake = 1'b0;
            end
        end
        wake = 1'b0;
        check(c0 == SRX && c1 == SRX && c2 != SRX, "R2 two exit commands",
              int'({c0, c1, c2}), int'({SRX, SRX, NOP}));
        check(first_aref == 2 + N, "R3 settle NOP cycles", first_aref, 2 + N);
        if (mism != 0) $display("  first mismatch at cycle %0d", first_i);
        check(mism == 0, "R4 refresh spacing trace", first_act, first_exp);
        check(nref == ROWS, "R8 refresh count", nref, ROWS);
        check(done_at == total, "R5 done cycle", done_at, total);
        check(dn_bad == 0, "R5 done and ref_en levels", dn_bad, 0);
        check(cke_bad == 0, "R9 cke held high", cke_bad, 0);
        check(busy_wakes == 0 || mism == 0, "R6 busy wake and gap ignored", mism, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check(cmd === NOP && cke === 1'b0 && ref_en === 1'b0 && done === 1'b0,
              "R1 reset state", int'({cmd, cke, ref_en, done}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            rfc_gap = 8'($urandom);
            @(negedge clk);
        end
        check(cmd === NOP && cke === 1'b0 && ref_en === 1'b0 && done === 1'b0,
              "R1 idle without wake", int'({cmd, cke, ref_en, done}), 0);
        run_seq(0, 1'b0);
        repeat (5) @(negedge clk);
        check(done === 1'b1 && ref_en === 1'b1 && cmd === NOP, "R5 done held",
              int'({done, ref_en, cmd}), int'({1'b1, 1'b1, NOP}));
        run_seq(1, 1'b1);
        run_seq(int'($urandom % 3), 1'b1);
        run_seq(3, 1'b1);
        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total_checks++;
        bad_checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end
endmodule